// File: doc/BRIEF.md
# Dual LED Blink and Playback Gating Controller

This block drives two indicator pins for a voice playback device. A single flash phase, stepped by an external rate tick, is shared by both indicators. Each indicator is either lit steadily or blinks with that phase. When blinking, the two indicators either blink together or take turns. Either indicator can be made to light only while a voice section is playing. The first indicator can also be forced on whenever the current output volume is nonzero.

The second pin has two uses. It can act as the second indicator, or it can carry a general stop line. As a stop line it shows the inverse of a stop bit held elsewhere. All configuration arrives as plain level inputs, and both pins are registered.

There is no data stream here. Every input and output is a plain control or status level, so no valid/ready handshake is involved.

Top module: `led_flash_ctrl`

## Requirements
- R1: While `rst_n` is low, both pins read 0. The flash phase restarts at 0.
- R2: The flash phase inverts on each clock edge where `flash_tick` is 1. It holds on every other edge.
- R3: With `cfg_flash`=0 (steady), an indicator that is not blanked by its section gating reads 1.
- R4: With `cfg_flash`=1, `led1_o` reads the flash phase unless gating or the volume rule overrides it.
- R5: With `cfg_flash`=1 and the second pin used as an indicator, that pin reads the flash phase when `cfg_alt`=0 (synchronous). It reads the inverted phase when `cfg_alt`=1 (alternate).
- R6: With `cfg_led1_sect`=1 and `sect_active`=0, `led1_o` reads 0 unless the volume rule applies.
- R7: With `cfg_pin_led2`=1, `cfg_led2_sect`=1 and `sect_active`=0, `led2_stopc_o` reads 0.
- R8: With `cfg_pin_led2`=0, `led2_stopc_o` reads the inverse of `stop_c_bit`. The indicator settings and the phase have no effect on it.
- R9: With `cfg_vol_off`=0 and `vol_level` nonzero, `led1_o` reads 1 whatever the phase and gating. With `cfg_vol_off`=1, `vol_level` has no effect.
- R10: Both pins are registered. A change on any input shows on the pins after the next rising clock edge, not before. The phase used is the value after that edge's tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flash_tick | input | 1 | One-cycle pulse that advances the flash phase |
| sect_active | input | 1 | 1 while a voice section is playing |
| stop_c_bit | input | 1 | Stop bit shown inverted when the second pin is a stop line |
| vol_level | input | VOL_W | Current output volume; a nonzero value can light the first indicator |
| cfg_flash | input | 1 | 1 selects blinking, 0 selects steady |
| cfg_alt | input | 1 | 1 selects alternate blinking, 0 selects synchronous blinking |
| cfg_led1_sect | input | 1 | 1 gates the first indicator by `sect_active` |
| cfg_led2_sect | input | 1 | 1 gates the second indicator by `sect_active` |
| cfg_pin_led2 | input | 1 | 1 makes the second pin an indicator, 0 makes it the stop line |
| cfg_vol_off | input | 1 | 0 lets `vol_level` light the first indicator, 1 disables that |
| led1_o | output | 1 | First indicator, 1 = lit |
| led2_stopc_o | output | 1 | Second indicator (1 = lit) or inverted stop line |

## Verification
The embedded properties assume that every input is synchronous to `clk` and settled at each rising edge. They also assume that configuration and status inputs hold no unknown values once reset is released. The phase-step properties assume that `flash_tick` is a single-cycle level sampled once per edge. The bench changes inputs only on falling edges and holds them across the following rising edge. It sweeps every combination of the six configuration bits, section flag, stop bit, all volume values of a two-bit volume port and the tick. Outputs are sampled midway into the high phase of the clock.

// File: rtl/led_flash_pkg.sv
package led_flash_pkg;

  typedef struct packed {
    logic flash_en;   // blink instead of steady
    logic alt_flash;  // antiphase blinking of the second indicator
    logic led1_sect;  // first indicator gated by playback
    logic led2_sect;  // second indicator gated by playback
    logic pin_led2;   // second pin is an indicator (else stop line)
    logic vol_off;    // volume does not light the first indicator
  } led_mode_t;

  // Level of an indicator before the volume override is applied.
  function automatic logic gated_level(input logic base,
                                       input logic gate_en,
                                       input logic active);
    return (gate_en && !active) ? 1'b0 : base;
  endfunction

endpackage

// File: rtl/led_phase_gen.sv
module led_phase_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic phase_nx_o,
  output logic phase_q_o
);

  logic phase_q;

  assign phase_nx_o = phase_q ^ tick_i;
  assign phase_q_o  = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_nx_o;
  end

  // R2: a tick flips the phase
  a_r2_tick_flips: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (phase_q != $past(phase_q)));

  // R2: no tick, no change
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(phase_q));

endmodule

// File: rtl/led1_path.sv
module led1_path
  import led_flash_pkg::*;
#(
  parameter int VOL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  led_mode_t        mode_i,
  input  logic             phase_nx_i,
  input  logic             sect_i,
  input  logic [VOL_W-1:0] vol_i,
  output logic             led_o
);

  logic vol_force;
  logic base;
  logic led_d;

  assign vol_force = !mode_i.vol_off && (vol_i != '0);
  assign base      = mode_i.flash_en ? phase_nx_i : 1'b1;
  assign led_d     = vol_force ? 1'b1
                               : gated_level(base, mode_i.led1_sect, sect_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_o <= 1'b0;
    else        led_o <= led_d;
  end

  // R9: nonzero volume with follow enabled lights the indicator
  a_r9_volume_lights: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i.vol_off && (vol_i != '0)) |=> led_o);

  // R6: gated and idle, with no volume override, stays dark
  a_r6_led1_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i.led1_sect && !sect_i && (mode_i.vol_off || vol_i == '0))
      |=> !led_o);

  // R3: steady and not blanked means lit
  a_r3_led1_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i.flash_en && !(mode_i.led1_sect && !sect_i)) |=> led_o);

endmodule

// File: rtl/led2_pin_path.sv
module led2_pin_path
  import led_flash_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  led_mode_t mode_i,
  input  logic      phase_nx_i,
  input  logic      sect_i,
  input  logic      stop_i,
  output logic      pin_o
);

  logic blink_lvl;
  logic base;
  logic pin_d;

  assign blink_lvl = mode_i.alt_flash ? ~phase_nx_i : phase_nx_i;
  assign base      = mode_i.flash_en ? blink_lvl : 1'b1;
  assign pin_d     = mode_i.pin_led2 ? gated_level(base, mode_i.led2_sect, sect_i)
                                     : ~stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_o <= 1'b0;
    else        pin_o <= pin_d;
  end

  // R8: stop line shows the inverted stop bit
  a_r8_stop_line: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i.pin_led2 |=> (pin_o == !$past(stop_i)));

  // R7: second indicator dark while gated and idle
  a_r7_led2_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i.pin_led2 && mode_i.led2_sect && !sect_i) |=> !pin_o);

  // R3: steady second indicator, not blanked, is lit
  a_r3_led2_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i.pin_led2 && !mode_i.flash_en && !(mode_i.led2_sect && !sect_i))
      |=> pin_o);

endmodule

// File: rtl/led_flash_ctrl.sv
module led_flash_ctrl
  import led_flash_pkg::*;
#(
  parameter int VOL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flash_tick,
  input  logic             sect_active,
  input  logic             stop_c_bit,
  input  logic [VOL_W-1:0] vol_level,
  input  logic             cfg_flash,
  input  logic             cfg_alt,
  input  logic             cfg_led1_sect,
  input  logic             cfg_led2_sect,
  input  logic             cfg_pin_led2,
  input  logic             cfg_vol_off,
  output logic             led1_o,
  output logic             led2_stopc_o
);

  led_mode_t mode;
  logic      phase_nx;
  logic      phase_q;

  always_comb begin
    mode.flash_en  = cfg_flash;
    mode.alt_flash = cfg_alt;
    mode.led1_sect = cfg_led1_sect;
    mode.led2_sect = cfg_led2_sect;
    mode.pin_led2  = cfg_pin_led2;
    mode.vol_off   = cfg_vol_off;
  end

  led_phase_gen u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (flash_tick),
    .phase_nx_o (phase_nx),
    .phase_q_o  (phase_q)
  );

  led1_path #(.VOL_W(VOL_W)) u_led1 (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .phase_nx_i (phase_nx),
    .sect_i     (sect_active),
    .vol_i      (vol_level),
    .led_o      (led1_o)
  );

  led2_pin_path u_led2 (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .phase_nx_i (phase_nx),
    .sect_i     (sect_active),
    .stop_i     (stop_c_bit),
    .pin_o      (led2_stopc_o)
  );

  logic plain_blink;
  assign plain_blink = cfg_flash && cfg_pin_led2 && !cfg_led1_sect &&
                       !cfg_led2_sect && (cfg_vol_off || vol_level == '0);

  // R5: alternate blinking puts the indicators in antiphase
  a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_blink && cfg_alt) |=> (led1_o != led2_stopc_o));

  // R5: synchronous blinking keeps them equal
  a_r5_synchronous: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_blink && !cfg_alt) |=> (led1_o == led2_stopc_o));

  // R4: ungated blinking first indicator follows the new phase
  a_r4_led1_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flash && !cfg_led1_sect && (cfg_vol_off || vol_level == '0))
      |=> (led1_o == phase_q));

endmodule

// File: tb/led_flash_ctrl_bench.sv
module led_flash_ctrl_bench;

  localparam int VW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flash_tick = 1'b0, sect_active = 1'b0, stop_c_bit = 1'b0;
  logic [VW-1:0] vol_level = '0;
  logic cfg_flash = 1'b0, cfg_alt = 1'b0, cfg_led1_sect = 1'b0;
  logic cfg_led2_sect = 1'b0, cfg_pin_led2 = 1'b0, cfg_vol_off = 1'b0;
  logic led1_o, led2_stopc_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  led_flash_ctrl #(.VOL_W(VW)) u_led_flash_ctrl (
    .clk(clk), .rst_n(rst_n), .flash_tick(flash_tick),
    .sect_active(sect_active), .stop_c_bit(stop_c_bit), .vol_level(vol_level),
    .cfg_flash(cfg_flash), .cfg_alt(cfg_alt), .cfg_led1_sect(cfg_led1_sect),
    .cfg_led2_sect(cfg_led2_sect), .cfg_pin_led2(cfg_pin_led2),
    .cfg_vol_off(cfg_vol_off), .led1_o(led1_o), .led2_stopc_o(led2_stopc_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ph, e1, e2, p1, p2, vol_on, b1, b2;
    string t1, t2;
    ph = 1'b0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 led1 in reset", led1_o, 1'b0);
    chk("R1 pin2 in reset", led2_stopc_o, 1'b0);
    rst_n = 1'b1;
    p1 = 1'b0; p2 = 1'b0;

    // R2: tick stepping, ungated blinking, synchronous
    cfg_flash = 1'b1; cfg_pin_led2 = 1'b1; cfg_vol_off = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      flash_tick = k[0] | k[2];
      @(posedge clk); #5;
      ph = ph ^ flash_tick;
      chk("R2 phase step", led1_o, ph);
    end
    p1 = ph; p2 = ph;

    // Full sweep
    for (int m = 0; m < 64; m++)
      for (int s = 0; s < 2; s++)
        for (int st = 0; st < 2; st++)
          for (int v = 0; v < 4; v++)
            for (int tk = 0; tk < 2; tk++) begin
              @(negedge clk);
              cfg_flash = m[0]; cfg_alt = m[1]; cfg_led1_sect = m[2];
              cfg_led2_sect = m[3]; cfg_pin_led2 = m[4]; cfg_vol_off = m[5];
              sect_active = s[0]; stop_c_bit = st[0];
              vol_level = v[VW-1:0]; flash_tick = tk[0];
              #1;
              // R10: nothing moves before the edge
              chk("R10 led1 held", led1_o, p1);
              chk("R10 pin2 held", led2_stopc_o, p2);
              ph = ph ^ tk[0];
              vol_on = !m[5] && (v != 0);
              b1 = m[0] ? ph : 1'b1;
              b2 = m[0] ? (m[1] ? !ph : ph) : 1'b1;
              if (vol_on) begin e1 = 1'b1; t1 = "R9 volume"; end
              else if (m[2] && !s[0]) begin e1 = 1'b0; t1 = "R6 led1 gated"; end
              else if (m[0]) begin e1 = b1; t1 = "R4 led1 blink"; end
              else begin e1 = 1'b1; t1 = "R3 led1 steady"; end
              if (!m[4]) begin e2 = !st[0]; t2 = "R8 stop line"; end
              else if (m[3] && !s[0]) begin e2 = 1'b0; t2 = "R7 led2 gated"; end
              else if (m[0]) begin e2 = b2; t2 = "R5 led2 blink"; end
              else begin e2 = 1'b1; t2 = "R3 led2 steady"; end
              @(posedge clk); #5;
              chk(t1, led1_o, e1);
              chk(t2, led2_stopc_o, e2);
              p1 = e1; p2 = e2;
            end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule